// File: doc/BRIEF.md
# Pipelined double-precision floating-point multiplier

This block multiplies two IEEE-754 binary64 operands in a fixed-depth pipeline. A pair of operands, a two-bit rounding-direction code and an input strobe are presented on one clock edge. The rounded product appears with an output strobe exactly 21 edges later. A fresh pair may be presented on every edge, so once the pipeline is full one product leaves it each cycle.

Internally the result sign is the XOR of the operand signs. The biased exponents are summed and the bias is subtracted. The two 53-bit significands (hidden bit restored) are multiplied as a set of narrow partial products, which are summed in a separate stage. The 106-bit product is normalised by at most one place and then rounded in the selected direction. Subnormal operands count as zero. An infinite or NaN operand forces an infinite result. Results beyond the exponent range saturate to signed infinity. Results below the smallest normal exponent collapse to signed zero. Idle stages are padded with plain registers, so the depth is a parameter.

Top module: `fmul_pipe`

## Requirements
- R1: An operand pair accepted with `in_valid` high on a rising edge produces `out_valid` high and its `product` exactly 21 rising edges later; no other output strobes occur.
- R2: A new operand pair may be accepted on every edge, including back-to-back and with idle gaps; products leave in the order their operands entered.
- R3: With `rnd_mode` = 0 (nearest, ties to even), the product of two normal finite operands equals the correctly rounded binary64 product, and its sign is the XOR of the operand signs.
- R4: With `rnd_mode` = 1 (toward zero), the significand of an inexact product is truncated.
- R5: With `rnd_mode` = 2 (toward plus infinity), a positive inexact product is rounded up in magnitude and a negative one is truncated.
- R6: With `rnd_mode` = 3 (toward minus infinity), a negative inexact product is rounded up in magnitude and a positive one is truncated.
- R7: An operand whose exponent field (bits 62:52) is zero counts as zero: when no operand is infinite or NaN, the result is a zero whose sign is the XOR of the operand signs.
- R8: If either operand has exponent field 2047 (infinity or NaN), the result is infinity (exponent 2047, fraction 0) with XOR sign; this takes priority over a zero operand.
- R9: When the rounded result exponent is 2047 or more, the result is signed infinity. When it is 0 or less, the result is signed zero. No subnormal or NaN encoding is ever produced.
- R10: When the significand product reaches 2.0, or rounding carries out of the significand, the exponent is raised by one and the fraction renormalised.
- R11: A synchronous reset empties the pipeline: `out_valid` is low on the edge after reset and stays low until new operands have travelled the full depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears the stage strobes |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| rnd_mode | input | 2 | Rounding: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Product present this cycle |
| product | output | 64 | Rounded binary64 product |

## Verification
A corrupted stage strobe shows as a missing or extra `out_valid` exactly 21 cycles after the operands that should have set it. Sign, exponent and class information that drifts by one stage against the significand pipeline pairs one operation's exponent with a neighbour's significand. That shows on the first product after the error. A fault in the partial-product sum or the rounding increment shows as a one-ulp or larger difference on inexact products. The rounding sweeps exercise every direction code with both signs, ties and carry-outs to expose it.

// File: rtl/fmul_pkg.sv
`timescale 1ns/1ps
package fmul_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XEXP_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic                      sign;
        logic signed [XEXP_W-1:0]  exp;
        logic                      is_zero;
        logic                      is_inf;
        rnd_mode_e                 mode;
    } side_t;
endpackage

// File: rtl/fmul_unpack.sv
`timescale 1ns/1ps
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic [63:0]        a,
    input  logic [63:0]        b,
    input  logic [1:0]         mode,
    output side_t              side,
    output logic [SIG_W-1:0]   sig_a,
    output logic [SIG_W-1:0]   sig_b
);
    logic [EXP_W-1:0] ea, eb;
    logic za, zb;

    assign ea = a[62:52];
    assign eb = b[62:52];
    assign za = (ea == '0);
    assign zb = (eb == '0);

    // a zero exponent field flushes the operand, hidden bit included
    assign sig_a = za ? '0 : {1'b1, a[FRAC_W-1:0]};
    assign sig_b = zb ? '0 : {1'b1, b[FRAC_W-1:0]};

    always_comb begin
        side.sign    = a[63] ^ b[63];
        side.exp     = $signed({2'b00, ea}) + $signed({2'b00, eb})
                       - $signed(XEXP_W'(BIAS));
        side.is_zero = za | zb;
        side.is_inf  = (ea == EXP_W'(EMAX)) | (eb == EXP_W'(EMAX));
        side.mode    = rnd_mode_e'(mode);
    end
endmodule

// File: rtl/fmul_delay.sv
`timescale 1ns/1ps
module fmul_delay #(
    parameter int WIDTH  = 1,
    parameter int DEPTH  = 1,
    parameter bit RST_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (RST_EN && rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[DEPTH-1];
endmodule

// File: rtl/fmul_sigmul.sv
`timescale 1ns/1ps
module fmul_sigmul #(
    parameter int SIG_W = 53,
    parameter int CHUNK = 18
) (
    input  logic              clk,
    input  logic [SIG_W-1:0]  a,
    input  logic [SIG_W-1:0]  b,
    output logic [2*SIG_W-1:0] prod
);
    localparam int NCH = (SIG_W + CHUNK - 1) / CHUNK;
    localparam int PPW = SIG_W + CHUNK;
    localparam int PW  = 2 * SIG_W;

    logic [NCH*CHUNK-1:0] b_pad;
    logic [PPW-1:0]       pp_q [NCH];
    logic [PW-1:0]        acc;

    assign b_pad = (NCH*CHUNK)'(b);

    // stage A: one narrow partial product per slice of b
    for (genvar i = 0; i < NCH; i++) begin : g_pp
        always_ff @(posedge clk)
            pp_q[i] <= PPW'(a) * PPW'(b_pad[i*CHUNK +: CHUNK]);
    end

    // stage B: weighted sum of the slices
    always_comb begin
        acc = '0;
        for (int i = 0; i < NCH; i++)
            acc = acc + (PW'(pp_q[i]) << (i * CHUNK));
    end

    always_ff @(posedge clk) prod <= acc;
endmodule

// File: rtl/fmul_round.sv
`timescale 1ns/1ps
module fmul_round
    import fmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              v_in,
    input  side_t             side,
    input  logic [PROD_W-1:0] prod,
    output logic              v_out,
    output logic [63:0]       res
);
    logic                     hi, guard, sticky, inc, carry;
    logic [SIG_W-1:0]         mant;
    logic [SIG_W:0]           sum;
    logic [FRAC_W-1:0]        frac;
    logic signed [XEXP_W-1:0] e_fin;
    logic [63:0]              res_d;

    assign hi = prod[PROD_W-1];

    always_comb begin
        if (hi) begin
            mant   = prod[PROD_W-1 -: SIG_W];
            guard  = prod[SIG_W-1];
            sticky = |prod[SIG_W-2:0];
        end else begin
            mant   = prod[PROD_W-2 -: SIG_W];
            guard  = prod[SIG_W-2];
            sticky = |prod[SIG_W-3:0];
        end
        unique case (side.mode)
            RND_NEAR: inc = guard & (sticky | mant[0]);
            RND_ZERO: inc = 1'b0;
            RND_POS:  inc = ~side.sign & (guard | sticky);
            RND_NEG:  inc =  side.sign & (guard | sticky);
        endcase
        sum   = {1'b0, mant} + (SIG_W+1)'(inc);
        carry = sum[SIG_W];
        frac  = carry ? '0 : sum[FRAC_W-1:0];
        e_fin = side.exp + $signed({{(XEXP_W-1){1'b0}}, hi})
                         + $signed({{(XEXP_W-1){1'b0}}, carry});

        if (side.is_inf)
            res_d = {side.sign, EXP_W'(EMAX), {FRAC_W{1'b0}}};
        else if (side.is_zero)
            res_d = {side.sign, 63'd0};
        else if (e_fin >= $signed(XEXP_W'(EMAX)))
            res_d = {side.sign, EXP_W'(EMAX), {FRAC_W{1'b0}}};
        else if (e_fin <= 0)
            res_d = {side.sign, 63'd0};
        else
            res_d = {side.sign, e_fin[EXP_W-1:0], frac};
    end

    always_ff @(posedge clk) begin
        if (rst) v_out <= 1'b0;
        else     v_out <= v_in;
    end

    always_ff @(posedge clk) res <= res_d;

    // R10: normal operands always give a product in [1,4)
    p_prod_norm_r10: assert property (@(posedge clk) disable iff (rst)
        (v_in && !side.is_zero && !side.is_inf) |-> (|prod[PROD_W-1 -: 2]));

    // R8: non-finite class flag must reach the port as infinity
    p_special_inf_r8: assert property (@(posedge clk) disable iff (rst)
        (v_in && side.is_inf) |=> (res[62:52] == EXP_W'(EMAX) && res[51:0] == '0));

    // R9: no subnormal and no NaN encodings
    p_no_subnormal_r9: assert property (@(posedge clk) disable iff (rst)
        v_out |-> ((res[62:52] != '0 || res[51:0] == '0) &&
                   (res[62:52] != EXP_W'(EMAX) || res[51:0] == '0)));

    // R3: result sign follows the carried operand sign
    p_sign_r3: assert property (@(posedge clk) disable iff (rst)
        v_in |=> (res[63] == $past(side.sign)));
endmodule

// File: rtl/fmul_pipe.sv
`timescale 1ns/1ps
module fmul_pipe
    import fmul_pkg::*;
#(
    parameter int LATENCY = 21,
    parameter int CHUNK   = 18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [1:0]  rnd_mode,
    output logic        out_valid,
    output logic [63:0] product
);
    // stages: capture(1) + multiply(2) + padding + round(1)
    localparam int PAD    = LATENCY - 4;
    localparam int SIDE_W = $bits(side_t);

    side_t              side_d, s1_side, side_late;
    logic [SIG_W-1:0]   sig_a_d, sig_b_d, s1_a, s1_b;
    logic               s1_v, v_late;
    logic [PROD_W-1:0]  prod_mul, prod_late;
    logic [SIDE_W-1:0]  side_bits;

    fmul_unpack u_unpack (
        .a(op_a), .b(op_b), .mode(rnd_mode),
        .side(side_d), .sig_a(sig_a_d), .sig_b(sig_b_d)
    );

    always_ff @(posedge clk) begin
        if (rst) s1_v <= 1'b0;
        else     s1_v <= in_valid;
    end

    always_ff @(posedge clk) begin
        s1_side <= side_d;
        s1_a    <= sig_a_d;
        s1_b    <= sig_b_d;
    end

    fmul_sigmul #(.SIG_W(SIG_W), .CHUNK(CHUNK)) u_mul (
        .clk(clk), .a(s1_a), .b(s1_b), .prod(prod_mul)
    );

    fmul_delay #(.WIDTH(PROD_W), .DEPTH(PAD), .RST_EN(1'b0)) u_dly_prod (
        .clk(clk), .rst(rst), .d(prod_mul), .q(prod_late)
    );

    fmul_delay #(.WIDTH(SIDE_W), .DEPTH(PAD + 2), .RST_EN(1'b0)) u_dly_side (
        .clk(clk), .rst(rst), .d(s1_side), .q(side_bits)
    );

    fmul_delay #(.WIDTH(1), .DEPTH(PAD + 2), .RST_EN(1'b1)) u_dly_vld (
        .clk(clk), .rst(rst), .d(s1_v), .q(v_late)
    );

    assign side_late = side_bits;

    fmul_round u_round (
        .clk(clk), .rst(rst), .v_in(v_late), .side(side_late),
        .prod(prod_late), .v_out(out_valid), .res(product)
    );

    // R11: the edge after reset shows an empty pipeline
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/sim_fmul_pipe.sv
`timescale 1ns/1ps
module sim_fmul_pipe;
    localparam int LAT  = 21;
    localparam int MAXN = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [63:0] product;

    fmul_pipe u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .product(product)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int nops = 0, rx = 0;
    logic [63:0] va [MAXN], vb [MAXN], vexp [MAXN];
    logic [1:0]  vm [MAXN];
    int          vcyc [MAXN];
    string       vtag [MAXN];
    bit mon_en = 1'b1;
    bit done = 1'b0;
    logic [63:0] rs = 64'h9E3779B97F4A7C15;

    function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    function automatic logic [63:0] rnd64();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    // reference product from the stated rules
    function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] m);
        logic s; int ea, eb, e, sh; logic [105:0] p, rem, half; logic [53:0] keep; bit up;
        s = a[63] ^ b[63]; ea = int'(a[62:52]); eb = int'(b[62:52]);
        if (ea == 2047 || eb == 2047) return {s, 11'h7FF, 52'd0};
        if (ea == 0 || eb == 0) return {s, 63'd0};
        p = 106'({1'b1, a[51:0]}) * 106'({1'b1, b[51:0]});
        sh = p[105] ? 53 : 52;
        e = ea + eb - 1023 + (p[105] ? 1 : 0);
        keep = 54'(p >> sh);
        rem  = p & ((106'd1 << sh) - 106'd1);
        half = 106'd1 << (sh - 1);
        case (m)
            2'd0: up = (rem > half) || (rem == half && keep[0]);
            2'd1: up = 1'b0;
            2'd2: up = !s && rem != 0;
            default: up = s && rem != 0;
        endcase
        keep = keep + 54'(up);
        if (keep[53]) begin keep = keep >> 1; e = e + 1; end
        if (e >= 2047) return {s, 11'h7FF, 52'd0};
        if (e <= 0) return {s, 63'd0};
        return {s, 11'(e), keep[51:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic add_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] m, input string tag);
        va[nops] = a; vb[nops] = b; vm[nops] = m; vtag[nops] = tag;
        vexp[nops] = ref_mul(a, b, m);
        nops++;
    endtask

    // output monitor: latency/order (R1, R2) and value checks
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (rx >= nops) begin
                check(1'b0, "R1 extra strobe", 64'(rx), 64'(nops));
            end else begin
                check(cyc == vcyc[rx] + LAT, "R1 latency", 64'(cyc), 64'(vcyc[rx] + LAT));
                check(product === vexp[rx], vtag[rx], product, vexp[rx]);
                if (vm[rx] == 2'd0 && va[rx][62:52] > 900 && va[rx][62:52] < 1150 &&
                    vb[rx][62:52] > 900 && vb[rx][62:52] < 1150) begin
                    logic [63:0] rv;
                    rv = $realtobits($bitstoreal(va[rx]) * $bitstoreal(vb[rx]));
                    check(product === rv, "R3 native multiply", product, rv);
                end
            end
            rx++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", rx, nops);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] one, ulp1, allf, maxf;
        one  = mk(0, 1023, 52'd0);
        ulp1 = mk(0, 1023, 52'd1);
        allf = mk(0, 1023, {52{1'b1}});
        maxf = mk(0, 2046, {52{1'b1}});
        for (int m = 0; m < 4; m++) begin
            add_op(one, one, 2'(m), "R3 unity");
            add_op(mk(0,1023,52'h8000000000000), mk(0,1023,52'h8000000000000), 2'(m), "R10 norm shift");
            add_op(allf, allf, 2'(m), "R10 round carry");
            add_op(ulp1, ulp1, 2'(m), "R5 inexact positive");
            add_op(mk(1,1023,52'd1), ulp1, 2'(m), "R6 inexact negative");
            add_op(mk(0,1023,52'd1 << 25), mk(0,1023,52'd1 << 26), 2'(m), "R3 tie even");
            add_op(mk(1,1023,52'h8000000000000), ulp1, 2'(m), "R4 tie odd");
            add_op(mk(0,2000,52'h123), mk(1,2000,52'h9), 2'(m), "R9 overflow");
            add_op(mk(1,10,52'h5), mk(0,10,52'h7), 2'(m), "R9 underflow");
            add_op(mk(0,0,52'h12345), mk(0,1024,52'd0), 2'(m), "R7 subnormal");
            add_op(mk(0,0,52'd0), mk(1,1024,52'h8000000000000), 2'(m), "R7 signed zero");
            add_op(mk(0,2047,52'd0), mk(0,0,52'd0), 2'(m), "R8 inf times zero");
            add_op(mk(0,2047,52'h1), one, 2'(m), "R8 nan");
            add_op(mk(1,2047,52'd0), mk(0,1024,52'd0), 2'(m), "R8 negative inf");
            add_op(maxf, ulp1, 2'(m), "R9 max overflow");
            add_op(mk(0,512,52'h3), mk(1,512,52'h1), 2'(m), "R9 min normal");
            add_op(mk(0,511,52'h3), mk(0,512,52'h1), 2'(m), "R9 below normal");
        end
        for (int i = 0; i < 240; i++) begin
            logic [63:0] x, y; int base, sp; string t;
            x = rnd64(); y = rnd64();
            case (i % 3)
                0: begin base = 1000; sp = 47; end
                1: begin base = 1500; sp = 80; end
                default: begin base = 480; sp = 80; end
            endcase
            x[62:52] = 11'(base + int'(x[62:52]) % sp);
            y[62:52] = 11'(base + int'(y[62:52]) % sp);
            case (i % 4)
                0: t = "R3 random nearest";
                1: t = "R4 random toward zero";
                2: t = "R5 random toward plus";
                default: t = "R6 random toward minus";
            endcase
            add_op(x, y, 2'(i % 4), t);
        end

        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R11 reset state", 64'(out_valid), 64'd0);
        rst = 1'b0;

        for (int k = 0; k < nops; k++) begin
            @(negedge clk);
            op_a = va[k]; op_b = vb[k]; rnd_mode = vm[k];
            in_valid = 1'b1; vcyc[k] = cyc;
            if (k % 7 == 6) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 5) @(negedge clk);
        check(rx == nops, "R2 product count", 64'(rx), 64'(nops));

        // R11: reset with a full pipeline discards every in-flight operation
        mon_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            op_a = one; op_b = one; in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < LAT + 10; k++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            check(!seen, "R11 flush on reset", 64'(seen), 64'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule